// File: doc/BRIEF.md
# Byte Logic and Word Arithmetic ALU Slice

This block is the logic-and-word-arithmetic slice of an 8-bit accumulator CPU datapath. On a strobe it does one of two things. It can combine the accumulator byte with a second byte by AND, OR or XOR. It can also add or subtract two 16-bit operands. The result, the eight-bit flag byte and the state it owns are captured in registers on that clock edge.

Word arithmetic is built from two byte lanes. The low lane takes the external carry-in, and its carry or borrow feeds the high lane. The flag byte follows the high lane, except that zero is judged over the full 16 bits. Each word operation also loads a hidden 16-bit pointer register with the first operand plus one.

A logical operation writes its result back into a held accumulator copy. All three logical operations share one flag routine, and the only flag that differs between them is the half-carry. Decode, register file and shifts live elsewhere.

Top module: `alu8w`

## Requirements
- R1: After reset, `result`, `flags`, `mem_ptr` and `acc_out` are all zero.
- R2: While `strobe` is low, `result`, `flags`, `mem_ptr` and `acc_out` keep their values.
- R3: The op codes are AND=0, OR=1, XOR=2. A strobed logical op combines `opnd_a[7:0]` with `opnd_b[7:0]`. The byte is written to `result[7:0]` and to `acc_out`, `result[15:8]` becomes 0, and `mem_ptr` is unchanged.
- R4: The flag byte layout is bit7 S, bit6 Z, bit5 Y, bit4 H, bit3 X, bit2 P/V, bit1 N, bit0 C. After a logical op, S is result bit 7, Z is 1 when the byte is zero, X is result bit 3 and Y is result bit 5.
- R5: After a logical op, H is 1 for AND and 0 for OR and XOR, and N and C are both 0.
- R6: After a logical op, P/V is 1 when the result byte has an even number of set bits.
- R7: ADDW (code 3) gives `result = opnd_a + opnd_b + carry_in` mod 2^16. C is the carry out of bit 15 and H is the carry out of bit 11. P/V is the signed 16-bit overflow and N is 0. S, Y and X are result bits 15, 13 and 11.
- R8: SUBW (code 4) gives `result = opnd_a - opnd_b - carry_in` mod 2^16. C is the borrow out of bit 15 and H is the borrow out of bit 11. P/V is the signed 16-bit overflow and N is 1. S, Y and X are result bits 15, 13 and 11.
- R9: After ADDW or SUBW, Z is 1 exactly when the whole 16-bit result is zero.
- R10: ADDW and SUBW load `mem_ptr` with `opnd_a + 1` mod 2^16 and leave `acc_out` unchanged.
- R11: A strobe with an op code of 5, 6 or 7 changes none of the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Perform the selected operation on this edge |
| op_sel | input | 3 | Operation code |
| opnd_a | input | 16 | First operand; low byte is the accumulator for logical ops |
| opnd_b | input | 16 | Second operand; low byte used for logical ops |
| carry_in | input | 1 | Carry/borrow into the low lane of word ops |
| result | output | 16 | Registered result |
| flags | output | 8 | Registered flag byte (S Z Y H X P/V N C) |
| mem_ptr | output | 16 | Hidden pointer, first word operand plus one |
| acc_out | output | 8 | Accumulator written back by logical ops |

## Verification
The assertions check on every cycle the properties that follow from the registered outputs themselves. These are: holding when no strobe is given, the fixed N/C/H values and the S/Z/X/Y mirroring of logical results, zero detection over 16 bits, and the pointer load with the accumulator kept. The arithmetic itself can only be shown by the bench scenarios, which compare against an independent 17-bit model. That covers carry chaining across the byte boundary, half-carry and overflow at bit 11 and bit 15, borrow on subtract, parity, and the ignored op codes.

// File: rtl/alu8w_pkg.sv
package alu8w_pkg;
  localparam int LANE_W  = 8;
  localparam int LANES   = 2;
  localparam int WORD_W  = LANE_W * LANES;
  localparam int NIB_W   = LANE_W / 2;
  localparam int OP_W    = 3;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 3'd0,
    OP_OR   = 3'd1,
    OP_XOR  = 3'd2,
    OP_ADDW = 3'd3,
    OP_SUBW = 3'd4
  } op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic y;
    logic h;
    logic x;
    logic pv;
    logic n;
    logic c;
  } flags_t;

  typedef struct packed {
    logic              cout;
    logic              half;
    logic              ovf;
    logic [LANE_W-1:0] sum;
  } lane_t;

  function automatic lane_t lane_calc(input logic [LANE_W-1:0] a,
                                      input logic [LANE_W-1:0] b,
                                      input logic cin, input logic sub);
    lane_t o;
    logic [LANE_W:0] t;
    logic [NIB_W:0]  lo;
    if (sub) begin
      t  = {1'b0, a} - {1'b0, b} - {{LANE_W{1'b0}}, cin};
      lo = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]} - {{NIB_W{1'b0}}, cin};
      o.ovf = (a[LANE_W-1] != b[LANE_W-1]) && (t[LANE_W-1] != a[LANE_W-1]);
    end else begin
      t  = {1'b0, a} + {1'b0, b} + {{LANE_W{1'b0}}, cin};
      lo = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
      o.ovf = (a[LANE_W-1] == b[LANE_W-1]) && (t[LANE_W-1] != a[LANE_W-1]);
    end
    o.cout = t[LANE_W];
    o.half = lo[NIB_W];
    o.sum  = t[LANE_W-1:0];
    return o;
  endfunction

  function automatic flags_t logic_flags(input logic [LANE_W-1:0] r, input logic h_val);
    flags_t f;
    f.s  = r[LANE_W-1];
    f.z  = (r == '0);
    f.y  = r[5];
    f.h  = h_val;
    f.x  = r[3];
    f.pv = ~^r;
    f.n  = 1'b0;
    f.c  = 1'b0;
    return f;
  endfunction
endpackage

// File: rtl/alu8w_logic.sv
module alu8w_logic
  import alu8w_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [LANE_W-1:0] acc,
  input  logic [LANE_W-1:0] val,
  output logic [LANE_W-1:0] res,
  output flags_t            flg
);
  logic is_and;

  always_comb begin
    is_and = 1'b0;
    unique case (op)
      OP_AND:  begin res = acc & val; is_and = 1'b1; end
      OP_OR:   res = acc | val;
      default: res = acc ^ val;
    endcase
    flg = logic_flags(res, is_and);
  end
endmodule

// File: rtl/alu8w_word.sv
module alu8w_word
  import alu8w_pkg::*;
(
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic              cin,
  input  logic              sub,
  output logic [WORD_W-1:0] res,
  output flags_t            flg
);
  logic  [LANES:0] chain;
  lane_t           lane [LANES];

  assign chain[0] = cin;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g]        = lane_calc(a[g*LANE_W +: LANE_W], b[g*LANE_W +: LANE_W],
                                      chain[g], sub);
    assign chain[g+1]     = lane[g].cout;
    assign res[g*LANE_W +: LANE_W] = lane[g].sum;
  end

  always_comb begin
    flg.s  = lane[LANES-1].sum[LANE_W-1];
    flg.z  = (res == '0);
    flg.y  = lane[LANES-1].sum[5];
    flg.h  = lane[LANES-1].half;
    flg.x  = lane[LANES-1].sum[3];
    flg.pv = lane[LANES-1].ovf;
    flg.n  = sub;
    flg.c  = chain[LANES];
  end
endmodule

// File: rtl/alu8w.sv
module alu8w
  import alu8w_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [2:0]        op_sel,
  input  logic [15:0]       opnd_a,
  input  logic [15:0]       opnd_b,
  input  logic              carry_in,
  output logic [15:0]       result,
  output logic [7:0]        flags,
  output logic [15:0]       mem_ptr,
  output logic [7:0]        acc_out
);
  logic              upd_logic;
  logic              upd_word;
  logic [LANE_W-1:0] lg_res;
  flags_t            lg_flg;
  logic [WORD_W-1:0] wd_res;
  flags_t            wd_flg;

  assign upd_logic = strobe && (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR);
  assign upd_word  = strobe && (op_sel == OP_ADDW || op_sel == OP_SUBW);

  alu8w_logic u_logic (
    .op  (op_sel),
    .acc (opnd_a[LANE_W-1:0]),
    .val (opnd_b[LANE_W-1:0]),
    .res (lg_res),
    .flg (lg_flg)
  );

  alu8w_word u_word (
    .a   (opnd_a),
    .b   (opnd_b),
    .cin (carry_in),
    .sub (op_sel == OP_SUBW),
    .res (wd_res),
    .flg (wd_flg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result  <= '0;
      flags   <= '0;
      mem_ptr <= '0;
      acc_out <= '0;
    end else if (upd_logic) begin
      result  <= {{(WORD_W-LANE_W){1'b0}}, lg_res};
      flags   <= lg_flg;
      acc_out <= lg_res;
    end else if (upd_word) begin
      result  <= wd_res;
      flags   <= wd_flg;
      mem_ptr <= opnd_a + 16'd1;
    end
  end
endmodule

// File: rtl/alu8w_chk.sv
module alu8w_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        strobe,
  input logic [2:0]  op_sel,
  input logic [15:0] opnd_a,
  input logic [15:0] result,
  input logic [7:0]  flags,
  input logic [15:0] mem_ptr,
  input logic [7:0]  acc_out
);
  logic is_lg, is_wd;
  assign is_lg = strobe && (op_sel <= 3'd2);
  assign is_wd = strobe && (op_sel == 3'd3 || op_sel == 3'd4);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(result) && $stable(flags) && $stable(mem_ptr) && $stable(acc_out));

  p_acc_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_lg |=> acc_out == result[7:0] && result[15:8] == 8'h00 && $stable(mem_ptr));

  p_szxy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_lg |=> flags[7] == result[7] && flags[6] == (result[7:0] == 8'h00)
              && flags[5] == result[5] && flags[3] == result[3]);

  p_h_and_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_lg |=> flags[4] == ($past(op_sel) == 3'd0) && flags[1:0] == 2'b00);

  p_wide_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_wd |=> flags[6] == (result == 16'h0000));

  p_ptr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    is_wd |=> mem_ptr == $past(opnd_a) + 16'd1 && $stable(acc_out));

  p_sub_n_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_wd |=> flags[1] == ($past(op_sel) == 3'd4));

  p_bad_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && op_sel >= 3'd5) |=> $stable(result) && $stable(flags)
                                   && $stable(mem_ptr) && $stable(acc_out));
endmodule

bind alu8w alu8w_chk chk_i (.*);

// File: tb/alu8w_tb_top.sv
module alu8w_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [15:0] opnd_a = '0, opnd_b = '0;
  logic        carry_in = 1'b0;
  logic [15:0] result, mem_ptr;
  logic [7:0]  flags, acc_out;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [15:0] e_res = '0, e_ptr = '0;
  logic [7:0]  e_flg = '0, e_acc = '0;

  always #2.5 clk = ~clk;

  alu8w dut_i (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic ci);
    logic [16:0] full;
    logic [7:0]  r8;
    logic        h, v;
    case (op)
      3'd0, 3'd1, 3'd2: begin
        r8 = (op == 3'd0) ? (a[7:0] & b[7:0]) : (op == 3'd1) ? (a[7:0] | b[7:0]) : (a[7:0] ^ b[7:0]);
        e_res = {8'h00, r8};
        e_acc = r8;
        e_flg = {r8[7], r8 == 8'h00, r8[5], op == 3'd0, r8[3], ~^r8, 2'b00};
      end
      3'd3: begin
        full  = {1'b0, a} + {1'b0, b} + 17'(ci);
        h     = ((13'(a[11:0]) + 13'(b[11:0]) + 13'(ci)) >= 13'h1000);
        v     = (a[15] == b[15]) && (full[15] != a[15]);
        e_res = full[15:0];
        e_ptr = a + 16'd1;
        e_flg = {full[15], full[15:0] == 16'h0, full[13], h, full[11], v, 1'b0, full[16]};
      end
      3'd4: begin
        full  = {1'b0, a} - {1'b0, b} - 17'(ci);
        h     = (13'(a[11:0]) < 13'(b[11:0]) + 13'(ci));
        v     = (a[15] != b[15]) && (full[15] != a[15]);
        e_res = full[15:0];
        e_ptr = a + 16'd1;
        e_flg = {full[15], full[15:0] == 16'h0, full[13], h, full[11], v, 1'b1, full[16]};
      end
      default: ;
    endcase
  endtask

  task automatic run(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                     input logic ci, input string tag);
    op_sel = op; opnd_a = a; opnd_b = b; carry_in = ci; strobe = 1'b1;
    model(op, a, b, ci);
    @(posedge clk);
    @(negedge clk);
    strobe = 1'b0;
    chk({tag, " result"},  result, e_res);
    chk({tag, " flags"},   {8'h00, flags}, {8'h00, e_flg});
    chk({tag, " acc R3 R10"}, {8'h00, acc_out}, {8'h00, e_acc});
    chk({tag, " ptr R3 R10"}, mem_ptr, e_ptr);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0A1B);
    repeat (3) @(negedge clk);
    chk("R1 result", result, 16'h0);
    chk("R1 flags", {8'h00, flags}, 16'h0);
    chk("R1 ptr", mem_ptr, 16'h0);
    chk("R1 acc", {8'h00, acc_out}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    run(3'd0, 16'h00F0, 16'h000F, 1'b0, "R4 R5 R6 and-zero");
    run(3'd0, 16'h00FF, 16'h00A8, 1'b0, "R4 R5 and-xy");
    run(3'd1, 16'h0001, 16'h0002, 1'b0, "R5 R6 or-even");
    run(3'd2, 16'h00FF, 16'h00FE, 1'b0, "R5 R6 xor-odd");
    run(3'd3, 16'hFFFF, 16'h0000, 1'b1, "R7 R9 add-wrap");
    run(3'd3, 16'h00FF, 16'h0000, 1'b1, "R7 add-chain");
    run(3'd3, 16'h0FFF, 16'h0001, 1'b0, "R7 add-half");
    run(3'd3, 16'h7FFF, 16'h0001, 1'b0, "R7 add-ovf");
    run(3'd4, 16'h0000, 16'h0000, 1'b1, "R8 sub-borrow");
    run(3'd4, 16'h1234, 16'h1234, 1'b0, "R8 R9 sub-zero");
    run(3'd4, 16'h0100, 16'h0000, 1'b1, "R8 sub-chain");
    run(3'd4, 16'h8000, 16'h0001, 1'b0, "R8 sub-ovf");
    run(3'd3, 16'h0100, 16'h0000, 1'b0, "R9 low-zero-only");

    // R2: inputs change with strobe low
    op_sel = 3'd3; opnd_a = 16'hAAAA; opnd_b = 16'h5555; carry_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 hold result", result, e_res);
    chk("R2 hold flags", {8'h00, flags}, {8'h00, e_flg});
    chk("R2 hold ptr", mem_ptr, e_ptr);

    // R11: unused codes
    for (int c = 5; c < 8; c++) begin
      run(3'(c), 16'h4321, 16'h8765, 1'b1, "R11 bad-op");
    end

    for (int i = 0; i < 400; i++) begin
      run(3'($urandom_range(0, 4)), 16'($urandom), 16'($urandom), 1'($urandom),
          "R3 R4 R5 R6 R7 R8 R9 R10 random");
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule